// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is a single-channel command mailbox between a host CPU and a security coprocessor. The host sees a small 32-bit register bus. It stages sixteen argument words and then writes a command word. That write commits the staged arguments together with the command as one request into a queue up to four entries deep. The coprocessor takes requests from the head of the queue through a valid/ready pop interface. When it has finished, it reports back with a completion strobe that loads a return-status word and sixteen result words for the host to read.

Three interrupt causes are kept in a write-1-to-clear register: command complete, command written while the queue was full, and queue has become full. A mask register with active-high suppress bits gates the causes onto a single level interrupt line. A status word reports the number of pending requests and mirrors a ready input from the coprocessor.

Back-pressure rules on the pop side: `pop_valid` is high whenever at least one request is pending. While `pop_valid` is high and `pop_ready` is low, the head entry does not change. A transfer happens on every clock edge where both are high. The host side has no back-pressure: a command write that finds the queue full is dropped and flagged.

Top module: `cmd_mailbox`

## Requirements
- R1: Bus writes to word offsets 0x00 through 0x3C (argument i at 0x00 + 4*i) store argument words, and a read at the same offset returns the stored word.
- R2: A bus write to offset 0x40 while fewer than 4 requests are pending appends one entry, made of the current sixteen argument words and the written command word, and raises the pending count by one. Offset 0x40 reads as zero.
- R3: The status word at offset 0xC4 carries the pending count in bits [2:0] and the level of `cp_ready` in bit 8. All its other bits read zero.
- R4: `pop_valid` is high exactly when the pending count is nonzero. `pop_cmd` and `pop_args` (argument i in bits [32*i+31:32*i]) show the oldest entry and stay stable while `pop_valid` is high and `pop_ready` is low. Each edge with both high removes that entry and lowers the count by one, and entries leave in the order they were written.
- R5: A command write while 4 requests are pending is dropped, even if a pop completes in the same cycle. It leaves the queue contents untouched and sets cause bit 17.
- R6: Cause bit 18 is set in the cycle in which the pending count becomes 4.
- R7: A `done_stb` pulse loads `done_status` into offset 0x80 and result word i (`done_results` bits [32*i+31:32*i]) into offset 0x84 + 4*i, and sets cause bit 0.
- R8: The cause register at 0xC8 holds bits 0, 17 and 18. Writing it clears each bit that has a 1 in the written data. A set event in the same cycle wins over the clear.
- R9: The mask register at 0xCC holds writable bits 0, 17 and 18, and all its other bits read zero. `irq` is high exactly when some cause bit is set and its mask bit is 0.
- R10: After reset, the cause register reads 0, the mask register reads 0x00060001, the pending count is 0, and the argument, status and result words read 0.
- R11: Offsets outside the argument, command, status, result, FIFO status, cause and mask words read zero. Writes to those offsets, and writes to the status, result and FIFO status words, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the access (word aligned) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| cp_ready | input | 1 | Coprocessor ready level, shown in status bit 8 |
| pop_valid | output | 1 | A pending request is at the head |
| pop_ready | input | 1 | Coprocessor accepts the head request |
| pop_cmd | output | DATA_W | Command word of the head request |
| pop_args | output | NUM_ARGS*DATA_W | Argument words of the head request |
| done_stb | input | 1 | Completion strobe, one cycle |
| done_status | input | DATA_W | Return-status word to load |
| done_results | input | NUM_ARGS*DATA_W | Result words to load |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with its default parameters: 32-bit words, sixteen arguments and a queue depth of 4. These are the only values for which the fixed register offsets and the 3-bit count field line up. At depth 4 the queue can be filled within a handful of writes, so the bench reaches the full flag, a dropped write, a dropped write coinciding with a pop, and draining the queue back to empty with order intact. It also holds the head under back-pressure and checks the interplay of completion, write-1-to-clear and masking on the interrupt line.

// File: rtl/cmd_mailbox_pkg.sv
package cmd_mailbox_pkg;
  // word indices (byte offset / 4) that software decodes
  localparam int unsigned WIDX_CMD    = 16;
  localparam int unsigned WIDX_STATUS = 32;
  localparam int unsigned WIDX_RES0   = 33;
  localparam int unsigned WIDX_FIFO   = 49;
  localparam int unsigned WIDX_CAUSE  = 50;
  localparam int unsigned WIDX_MASK   = 51;

  // bit positions inside cause, mask and FIFO status words
  localparam int unsigned BIT_DONE = 0;
  localparam int unsigned BIT_OVF  = 17;
  localparam int unsigned BIT_FULL = 18;
  localparam int unsigned BIT_RDY  = 8;

  typedef struct packed {
    logic full;
    logic ovf;
    logic done;
  } cause_t;
endpackage

// File: rtl/mbx_cmd_fifo.sv
module mbx_cmd_fifo #(
  parameter int unsigned W     = 544,
  parameter int unsigned DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [W-1:0]                     push_data,
  input  logic                             pop,
  output logic [W-1:0]                     head,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic                             full,
  output logic                             empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= nxt(wr_ptr);
      end
      if (pop) rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import cmd_mailbox_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t set_ev,
  input  logic   clr_wr,
  input  cause_t clr_bits,
  input  logic   mask_wr,
  input  cause_t mask_bits,
  output cause_t cause,
  output cause_t mask,
  output logic   irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause <= '0;
      mask  <= '1;
    end else begin
      cause <= set_ev | (cause & ~(clr_wr ? clr_bits : cause_t'('0)));
      if (mask_wr) mask <= mask_bits;
    end
  end

  assign irq = |(cause & ~mask);
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import cmd_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_ARGS = 16,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic                       cp_ready,
  output logic                       pop_valid,
  input  logic                       pop_ready,
  output logic [DATA_W-1:0]          pop_cmd,
  output logic [NUM_ARGS*DATA_W-1:0] pop_args,
  input  logic                       done_stb,
  input  logic [DATA_W-1:0]          done_status,
  input  logic [NUM_ARGS*DATA_W-1:0] done_results,
  output logic                       irq
);
  localparam int unsigned WIDX_W  = ADDR_W - 2;
  localparam int unsigned ENTRY_W = (NUM_ARGS + 1) * DATA_W;
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);

  logic [WIDX_W-1:0]  widx;
  logic [DATA_W-1:0]  arg_q [NUM_ARGS];
  logic [DATA_W-1:0]  res_q [NUM_ARGS];
  logic [DATA_W-1:0]  status_q;
  logic [NUM_ARGS*DATA_W-1:0] args_flat;
  logic [ENTRY_W-1:0] head;
  logic [CNT_W-1:0]   q_count;
  logic               q_full, q_empty;
  logic               cmd_wr, push_ok, pop_ok;
  cause_t             set_ev, cause, mask, wbits;

  assign widx   = bus_addr[ADDR_W-1:2];
  assign cmd_wr = bus_wr && (widx == WIDX_W'(WIDX_CMD));
  assign push_ok = cmd_wr && !q_full;
  assign pop_ok  = pop_valid && pop_ready;

  // argument staging and result words
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARGS; i++) begin
        arg_q[i] <= '0;
        res_q[i] <= '0;
      end
      status_q <= '0;
    end else begin
      for (int i = 0; i < NUM_ARGS; i++) begin
        if (bus_wr && widx == WIDX_W'(i)) arg_q[i] <= bus_wdata;
        if (done_stb) res_q[i] <= done_results[i*DATA_W +: DATA_W];
      end
      if (done_stb) status_q <= done_status;
    end
  end

  for (genvar g = 0; g < NUM_ARGS; g++) begin : g_flat
    assign args_flat[g*DATA_W +: DATA_W] = arg_q[g];
  end

  mbx_cmd_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push_ok),
    .push_data ({args_flat, bus_wdata}),
    .pop       (pop_ok),
    .head      (head),
    .count     (q_count),
    .full      (q_full),
    .empty     (q_empty)
  );

  assign pop_valid = !q_empty;
  assign pop_cmd   = head[DATA_W-1:0];
  assign pop_args  = head[ENTRY_W-1:DATA_W];

  // interrupt causes
  assign set_ev.done = done_stb;
  assign set_ev.ovf  = cmd_wr && q_full;
  assign set_ev.full = push_ok && !pop_ok && (q_count == CNT_W'(DEPTH - 1));
  assign wbits.done  = bus_wdata[BIT_DONE];
  assign wbits.ovf   = bus_wdata[BIT_OVF];
  assign wbits.full  = bus_wdata[BIT_FULL];

  mbx_irq_ctrl u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_ev    (set_ev),
    .clr_wr    (bus_wr && widx == WIDX_W'(WIDX_CAUSE)),
    .clr_bits  (wbits),
    .mask_wr   (bus_wr && widx == WIDX_W'(WIDX_MASK)),
    .mask_bits (wbits),
    .cause     (cause),
    .mask      (mask),
    .irq       (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_ARGS; i++) begin
      if (widx == WIDX_W'(i)) bus_rdata = arg_q[i];
      if (widx == WIDX_W'(WIDX_RES0 + i)) bus_rdata = res_q[i];
    end
    if (widx == WIDX_W'(WIDX_STATUS)) bus_rdata = status_q;
    if (widx == WIDX_W'(WIDX_FIFO)) begin
      bus_rdata[CNT_W-1:0] = q_count;
      bus_rdata[BIT_RDY]   = cp_ready;
    end
    if (widx == WIDX_W'(WIDX_CAUSE)) begin
      bus_rdata[BIT_DONE] = cause.done;
      bus_rdata[BIT_OVF]  = cause.ovf;
      bus_rdata[BIT_FULL] = cause.full;
    end
    if (widx == WIDX_W'(WIDX_MASK)) begin
      bus_rdata[BIT_DONE] = mask.done;
      bus_rdata[BIT_OVF]  = mask.ovf;
      bus_rdata[BIT_FULL] = mask.full;
    end
  end
endmodule

// File: rtl/cmd_mailbox_chk.sv
module cmd_mailbox_chk
  import cmd_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wr,
  input logic [CNT_W-1:0]  q_count,
  input logic              pop_valid,
  input logic              pop_ready,
  input logic [DATA_W-1:0] pop_cmd,
  input logic              done_stb,
  input cause_t            cause,
  input cause_t            mask,
  input logic              irq
);
  // R4: pending count never passes the queue depth
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  // R4: head held while stalled
  p_hold_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && !pop_ready |=> pop_valid && $stable(pop_cmd));

  // R4: valid follows pending count
  p_valid_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid == (q_count != '0));

  // R5: write to a full queue raises the overflow cause
  p_ovf_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && q_count == CNT_W'(DEPTH) |=> cause.ovf);

  // R5: write to a full queue without a pop leaves it full
  p_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && q_count == CNT_W'(DEPTH) && !pop_ready |=> q_count == CNT_W'(DEPTH));

  // R6: full cause appears only together with a full queue
  p_full_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause.full) |-> q_count == CNT_W'(DEPTH));

  // R7: completion raises the done cause
  p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_stb |=> cause.done);

  // R9: a fully masked block keeps the line low
  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> !irq);
endmodule

bind cmd_mailbox cmd_mailbox_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_wr    (cmd_wr),
  .q_count   (q_count),
  .pop_valid (pop_valid),
  .pop_ready (pop_ready),
  .pop_cmd   (pop_cmd),
  .done_stb  (done_stb),
  .cause     (cause),
  .mask      (mask),
  .irq       (irq)
);

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
  localparam int unsigned DW = 32;
  localparam int unsigned NA = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bus_wr = 1'b0;
  logic [7:0]       bus_addr = '0;
  logic [DW-1:0]    bus_wdata = '0;
  logic [DW-1:0]    bus_rdata;
  logic             cp_ready = 1'b1;
  logic             pop_valid;
  logic             pop_ready = 1'b0;
  logic [DW-1:0]    pop_cmd;
  logic [NA*DW-1:0] pop_args;
  logic             done_stb = 1'b0;
  logic [DW-1:0]    done_status = '0;
  logic [NA*DW-1:0] done_results = '0;
  logic             irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] rd;

  always #2.5 clk = ~clk;

  cmd_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cp_ready(cp_ready),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_cmd(pop_cmd),
    .pop_args(pop_args), .done_stb(done_stb), .done_status(done_status),
    .done_results(done_results), .irq(irq)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [DW-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pop_expect(input string req, input logic [DW-1:0] cmd, input logic [DW-1:0] arg0);
    @(negedge clk);
    check(req, {31'd0, pop_valid}, 32'd1);
    check(req, pop_cmd, cmd);
    check(req, pop_args[DW-1:0], arg0);
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
  endtask

  task automatic t_reset;
    rdreg(8'hC4, rd); check("R3 reset status", rd, 32'h0000_0100);
    rdreg(8'hC8, rd); check("R10 reset cause", rd, 32'h0);
    rdreg(8'hCC, rd); check("R10 reset mask", rd, 32'h0006_0001);
    rdreg(8'h3C, rd); check("R10 reset arg", rd, 32'h0);
    rdreg(8'h84, rd); check("R10 reset result", rd, 32'h0);
    check("R10 reset irq/valid", {30'd0, irq, pop_valid}, 32'd0);
    cp_ready = 1'b0;
    rdreg(8'hC4, rd); check("R3 ready bit low", rd, 32'h0);
    cp_ready = 1'b1;
  endtask

  task automatic t_args;
    for (int i = 0; i < NA; i++) wr(8'(4*i), 32'hA000_0000 + 32'(i * 32'h111));
    for (int i = 0; i < NA; i++) begin
      rdreg(8'(4*i), rd);
      check("R1 arg readback", rd, 32'hA000_0000 + 32'(i * 32'h111));
    end
    rdreg(8'h40, rd); check("R2 cmd reads zero", rd, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'hD0, 32'hFFFF_FFFF);
    wr(8'h80, 32'h1234_5678);
    wr(8'h88, 32'h1234_5678);
    wr(8'hC4, 32'hFFFF_FFFF);
    rdreg(8'h44, rd); check("R11 unmapped 0x44", rd, 32'h0);
    rdreg(8'hFC, rd); check("R11 unmapped 0xFC", rd, 32'h0);
    rdreg(8'h80, rd); check("R11 status read-only", rd, 32'h0);
    rdreg(8'h88, rd); check("R11 result read-only", rd, 32'h0);
    rdreg(8'hC4, rd); check("R11 fifo status read-only", rd, 32'h0000_0100);
    rdreg(8'h00, rd); check("R11 args untouched", rd, 32'hA000_0000);
  endtask

  task automatic t_queue;
    wr(8'h40, 32'h11);
    rdreg(8'hC4, rd); check("R2 count after push", rd, 32'h0000_0101);
    wr(8'h00, 32'hBEEF_0001);
    wr(8'h40, 32'h22);
    rdreg(8'hC4, rd); check("R3 count two", rd, 32'h0000_0102);
    // stall head for three cycles
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R4 head stable under stall", pop_cmd, 32'h11);
    end
    check("R4 stalled arg", pop_args[2*DW-1:DW], 32'hA000_0111);
    pop_expect("R4 pop first", 32'h11, 32'hA000_0000);
    rdreg(8'hC4, rd); check("R4 count after pop", rd, 32'h0000_0101);
    pop_expect("R4 pop second", 32'h22, 32'hBEEF_0001);
    check("R4 valid low when empty", {31'd0, pop_valid}, 32'd0);
  endtask

  task automatic t_full;
    for (int c = 1; c <= 4; c++) begin
      wr(8'h00, 32'h3000 + 32'(c));
      wr(8'h40, 32'h30 + 32'(c));
    end
    rdreg(8'hC4, rd); check("R6 count four", rd, 32'h0000_0104);
    rdreg(8'hC8, rd); check("R6 full cause", rd, 32'h0004_0000);
    check("R9 masked irq low", {31'd0, irq}, 32'd0);
    wr(8'h00, 32'h3005);
    wr(8'h40, 32'h35);
    rdreg(8'hC4, rd); check("R5 dropped write count", rd, 32'h0000_0104);
    rdreg(8'hC8, rd); check("R5 overflow cause", rd, 32'h0006_0000);
    // dropped write coinciding with a pop
    @(negedge clk);
    check("R5 head before pop", pop_cmd, 32'h31);
    bus_wr = 1'b1; bus_addr = 8'h40; bus_wdata = 32'h36; pop_ready = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; pop_ready = 1'b0;
    rdreg(8'hC4, rd); check("R5 pop wins nothing", rd, 32'h0000_0103);
    pop_expect("R5 order kept 2", 32'h32, 32'h3002);
    pop_expect("R5 order kept 3", 32'h33, 32'h3003);
    pop_expect("R5 order kept 4", 32'h34, 32'h3004);
    @(negedge clk);
    check("R5 no extra entry", {31'd0, pop_valid}, 32'd0);
  endtask

  task automatic t_complete;
    @(negedge clk);
    done_stb = 1'b1;
    done_status = 32'hC0DE_0001;
    for (int i = 0; i < NA; i++) done_results[i*DW +: DW] = 32'(i) * 32'h0101_0101 + 32'd5;
    @(negedge clk);
    done_stb = 1'b0;
    rdreg(8'h80, rd); check("R7 status word", rd, 32'hC0DE_0001);
    rdreg(8'h84, rd); check("R7 result 0", rd, 32'd5);
    rdreg(8'hC0, rd); check("R7 result 15", rd, 32'd15 * 32'h0101_0101 + 32'd5);
    rdreg(8'hC8, rd); check("R7 done cause", rd, 32'h0006_0001);
  endtask

  task automatic t_w1c;
    wr(8'hC8, 32'h0002_0000);
    rdreg(8'hC8, rd); check("R8 clear one bit", rd, 32'h0004_0001);
    wr(8'hC8, rd);
    rdreg(8'hC8, rd); check("R8 write back read value", rd, 32'h0);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'hC8; bus_wdata = 32'h1; done_stb = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; done_stb = 1'b0;
    rdreg(8'hC8, rd); check("R8 set wins over clear", rd, 32'h1);
    wr(8'hC8, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq;
    wr(8'hCC, 32'hFFFF_FFFF);
    rdreg(8'hCC, rd); check("R9 mask writable bits", rd, 32'h0006_0001);
    wr(8'hCC, 32'h0);
    check("R9 irq low, no cause", {31'd0, irq}, 32'd0);
    @(negedge clk);
    done_stb = 1'b1;
    @(negedge clk);
    done_stb = 1'b0;
    check("R9 irq on done", {31'd0, irq}, 32'd1);
    wr(8'hCC, 32'h1);
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(8'hCC, 32'h0);
    wr(8'hC8, 32'h1);
    check("R9 irq after clear", {31'd0, irq}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_args;
    t_unmapped;
    t_queue;
    t_full;
    t_complete;
    t_w1c;
    t_irq;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule